// File: doc/BRIEF.md
# Interval Timer with Watchdog Mode

This block is a free-running interval timer. A binary prescaler runs on the main system clock and feeds an 8-bit counter. One of four prescaler taps sets how fast the counter advances, so the time for the counter to roll over is one of four widely spaced reference periods. With the default taps these periods are 2^13, 2^15, 2^17 and 2^20 clocks, which is about 1.95 ms, 7.82 ms, 31.3 ms and 250 ms at 4.19 MHz. In interval mode, each rollover raises a one-clock interrupt request. The interrupt controller shares that request's vector slot with an external interrupt input; the controller is outside this block.

Software can switch the same counter into watchdog mode. In that mode a rollover raises a one-clock reset request instead of an interrupt, so software must clear the timer before each period ends. Only a system reset turns watchdog mode off. A new period select is held as pending and is applied at the next clear command.

Top module: `itwd_timer`

## Requirements
- R1: After a synchronous reset (`rstN` low at a clock edge), `irqReq` and `wdtRst` are low, the active select is 0, the pending select is 0, the mode is interval, and the prescaler and counter are zero.
- R2: With active select s, a rollover happens at the P-th clock edge after the reset or the clear, where P = 2^(TAP_LOG[s]+8). The output pulse is visible during the clock cycle that follows that edge.
- R3: Without a clear, rollovers repeat every P clocks and each one gives a pulse exactly one clock long.
- R4: A write with `wrData[3]`=1 (clear) sets the prescaler and counter to zero. It raises no request in the cycle after it, and it overrides a rollover that falls on the same edge. The next rollover comes P clocks after the clear.
- R5: When the watchdog mode bit is set, a rollover pulses `wdtRst` for one clock and `irqReq` stays low.
- R6: A write with `wrData[2]`=1 sets watchdog mode. A write with that bit at 0 does not turn the mode off; only reset does.
- R7: A write without the clear bit stores `wrData[1:0]` as the pending select. The active period stays unchanged until the next clear, which loads the pending select.
- R8: In a clear write, the `wrData[1:0]` field is ignored and the pending select is kept. A change to the mode bit takes effect for rollovers after the write's edge.
- R9: `irqReq` and `wdtRst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rstN | input | 1 | Synchronous active-low system reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 4 | [1:0] period select, [2] watchdog set, [3] clear |
| irqReq | output | 1 | Interval interrupt request, one-clock pulse |
| wdtRst | output | 1 | Watchdog reset request, one-clock pulse |

## Verification
Every request comes from a register. A pulse caused by the P-th edge after a clear or reset is therefore sampled at the falling edge that follows that edge. A write takes effect at the first rising edge where `wrEn` is high, so its result shows up half a cycle after that edge. The bench drives inputs on falling edges and steps a behavioural model on each rising edge, then compares both outputs on the next falling edge. Window counts of pulses confirm the period changes, the suppression by clears and the lock-in of watchdog mode, and each window is sized as a whole number of periods plus a small margin.

// File: rtl/itwd_pkg.sv
package itwd_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int WR_W    = 4;
  localparam int BIT_WD  = 2;
  localparam int BIT_CLR = 3;

  typedef struct packed {
    logic             clr;
    logic [SEL_W-1:0] sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/itwd_control.sv
module itwd_control
  import itwd_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  input  logic            ovf,
  output ctrlStrobe_t     ctrl,
  output logic            wdMode,
  output logic            irqReq,
  output logic            wdtRst
);
  logic [SEL_W-1:0] activeSel;
  logic [SEL_W-1:0] pendSel;
  logic             clrNow;

  assign clrNow   = wrEn && wrData[BIT_CLR];
  assign ctrl.clr = clrNow;
  assign ctrl.sel = activeSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel <= '0;
      pendSel   <= '0;
      wdMode    <= 1'b0;
    end else begin
      if (clrNow) begin
        activeSel <= pendSel;
      end else if (wrEn) begin
        pendSel <= wrData[SEL_W-1:0];
      end
      if (wrEn && wrData[BIT_WD]) begin
        wdMode <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      wdtRst <= 1'b0;
    end else begin
      irqReq <= ovf && !clrNow && !wdMode;
      wdtRst <= ovf && !clrNow && wdMode;
    end
  end
endmodule

// File: rtl/itwd_datapath.sv
module itwd_datapath
  import itwd_pkg::*;
#(
  parameter int TAP_LOG [NUM_SEL] = '{5, 7, 9, 12},
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  output logic             ovf,
  output logic [CNT_W-1:0] cntVal
);
  function automatic int maxTap();
    int m = 0;
    for (int i = 0; i < NUM_SEL; i++) if (TAP_LOG[i] > m) m = TAP_LOG[i];
    return m;
  endfunction

  localparam int PRE_W = maxTap() + 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] maskArr [NUM_SEL];
  logic [PRE_W-1:0] selMask;
  logic             tick;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_mask
    assign maskArr[g] = PRE_W'((64'(1) << TAP_LOG[g]) - 64'(1));
  end

  assign selMask = maskArr[ctrl.sel];
  assign tick    = (pre & selMask) == selMask;
  assign ovf     = tick && (cntVal == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clr) begin
      pre    <= '0;
      cntVal <= '0;
    end else begin
      pre <= pre + PRE_W'(1);
      if (tick) cntVal <= cntVal + CNT_W'(1);
    end
  end
endmodule

// File: rtl/itwd_timer.sv
module itwd_timer
  import itwd_pkg::*;
#(
  parameter int TAP_LOG [NUM_SEL] = '{5, 7, 9, 12},
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  output logic            irqReq,
  output logic            wdtRst
);
  ctrlStrobe_t      ctrl;
  logic             ovf;
  logic             wdModeW;
  logic [CNT_W-1:0] cntW;

  itwd_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .ovf(ovf),
    .ctrl(ctrl), .wdMode(wdModeW), .irqReq(irqReq), .wdtRst(wdtRst)
  );

  itwd_datapath #(.TAP_LOG(TAP_LOG), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .ovf(ovf), .cntVal(cntW)
  );
endmodule

// File: rtl/itwd_checker.sv
module itwd_checker
  import itwd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [WR_W-1:0]  wrData,
  input logic             irqReq,
  input logic             wdtRst,
  input logic             wdModeW,
  input logic [CNT_W-1:0] cntW
);
  AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq); // R3
  AST_WDT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst); // R5
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BIT_CLR]) |=> (!irqReq && !wdtRst)); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BIT_CLR]) |=> (cntW == '0)); // R4
  AST_WD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wdModeW |=> wdModeW); // R6
  AST_WDT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |-> wdModeW); // R5
  AST_NO_IRQ_IN_WD: assert property (@(posedge clk) disable iff (!rstN)
    $past(wdModeW) |-> !irqReq); // R5
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && wdtRst)); // R9
endmodule

bind itwd_timer itwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .irqReq(irqReq), .wdtRst(wdtRst), .wdModeW(wdModeW), .cntW(cntW)
);

// File: tb/itwd_timer_tb.sv
module itwd_timer_tb;
  localparam int TAPS [4] = '{0, 1, 2, 3};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrData = '0;
  logic       irqReq, wdtRst;

  int errors = 0, checks = 0;
  int irqCount = 0, wdtCount = 0;
  bit modelOn = 0;

  // behavioural reference
  int mElapsed = 0, mSel = 0, mPend = 0;
  bit mWd = 0, mIrq = 0, mWdt = 0;

  itwd_timer #(.TAP_LOG(TAPS)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .irqReq(irqReq), .wdtRst(wdtRst)
  );

  always #2 clk = ~clk;

  function automatic int periodOf(int s);
    return 1 << (TAPS[s] + 8);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mElapsed = 0; mSel = 0; mPend = 0; mWd = 0; mIrq = 0; mWdt = 0;
    end else begin
      mIrq = 0; mWdt = 0;
      if (wrEn && wrData[3]) begin
        mElapsed = 0;
        mSel = mPend;
      end else begin
        mElapsed++;
        if (mElapsed % periodOf(mSel) == 0) begin
          if (mWd) mWdt = 1; else mIrq = 1;
        end
        if (wrEn) mPend = wrData[1:0];
      end
      if (wrEn && wrData[2]) mWd = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      check(irqReq == mIrq, "R2 per-cycle irqReq vs model", irqReq, mIrq);
      check(wdtRst == mWdt, "R5 per-cycle wdtRst vs model", wdtRst, mWdt);
      check(!(irqReq && wdtRst), "R9 exclusive requests", irqReq + wdtRst, 1);
    end
    if (irqReq) irqCount++;
    if (wdtRst) wdtCount++;
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    waitCycles(3);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int c0, w0;
    waitCycles(4);
    rstN = 1'b1;
    modelOn = 1;
    check(irqReq == 0 && wdtRst == 0, "R1 outputs low after reset", irqReq + wdtRst, 0);

    // R2 R3: select 0 period 256, repeating
    c0 = irqCount;
    waitCycles(3 * 256 + 5);
    check(irqCount - c0 == 3, "R3 three periods at select 0", irqCount - c0, 3);

    // R7: pending select does not apply before a clear
    doWrite(4'b0010);
    c0 = irqCount;
    waitCycles(300);
    check(irqCount - c0 >= 1, "R7 old period still active", irqCount - c0, 1);

    // R7: clear loads pending select 2 (period 1024)
    doWrite(4'b1000);
    c0 = irqCount;
    waitCycles(2 * 1024 + 10);
    check(irqCount - c0 == 2, "R7 select 2 after clear", irqCount - c0, 2);

    // R8: clear write's select field ignored, pending 1 used (period 512)
    doWrite(4'b0001);
    doWrite(4'b1011);
    c0 = irqCount;
    waitCycles(2 * 512 + 10);
    check(irqCount - c0 == 2, "R8 clear select field ignored", irqCount - c0, 2);

    // R4: clears within the period suppress interrupts
    c0 = irqCount;
    for (int i = 0; i < 10; i++) begin
      doWrite(4'b1000);
      waitCycles(400);
    end
    check(irqCount - c0 == 0, "R4 frequent clears hold off irq", irqCount - c0, 0);

    // R5: watchdog set with clear, period 512
    doWrite(4'b1100);
    c0 = irqCount; w0 = wdtCount;
    waitCycles(2 * 512 + 10);
    check(wdtCount - w0 == 2, "R5 watchdog pulses", wdtCount - w0, 2);
    check(irqCount - c0 == 0, "R5 no irq in watchdog mode", irqCount - c0, 0);

    // R6: writing mode bit 0 does not leave watchdog mode
    doWrite(4'b0000);
    doWrite(4'b1000);
    c0 = irqCount; w0 = wdtCount;
    waitCycles(2 * 256 + 10);
    check(wdtCount - w0 == 2, "R6 watchdog stays on", wdtCount - w0, 2);
    check(irqCount - c0 == 0, "R6 irq stays off", irqCount - c0, 0);

    // R4: clears hold off the watchdog
    w0 = wdtCount;
    for (int i = 0; i < 5; i++) begin
      doWrite(4'b1000);
      waitCycles(200);
    end
    check(wdtCount - w0 == 0, "R4 clears hold off watchdog", wdtCount - w0, 0);

    // R6 R1: reset leaves watchdog mode
    doReset();
    check(irqReq == 0 && wdtRst == 0, "R1 outputs low after second reset", irqReq + wdtRst, 0);
    c0 = irqCount; w0 = wdtCount;
    waitCycles(256 + 5);
    check(irqCount - c0 == 1, "R6 interval mode after reset", irqCount - c0, 1);
    check(wdtCount - w0 == 0, "R6 no watchdog after reset", wdtCount - w0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule